// File: doc/BRIEF.md
# Device-ID State Control Mapper

This block turns enable and disable requests aimed at numbered devices into read-modify-write updates of packed control fields. Each request names a device by ID. A fixed range table maps that ID to a control register image, a bit offset, a field width and the codes for "on" and "off". A request rewrites only the target field. The two control register images are driven straight out of the block for the logic that gates the devices.

A second table maps device IDs onto fields of two status words that the block receives as inputs. A query port takes a device ID and returns, in the same cycle, whether that device reads as enabled, disabled, in some other state, or has no status field. Some devices have no off code. A disable request for one of them is refused and flagged. Requests for unmapped IDs are dropped and flagged.

Top module: `dsm_devstate_mapper`

## Requirements
- R1: While reset is low and on the first cycle after it, both control images read 0 and both flags read 0.
- R2: IDs 0 to 11 own bits [2*id+1:2*id] of control image A. Enable writes 2'b01 and disable writes 2'b00.
- R3: ID 12 owns bits [31:30] of control image A. Enable writes 2'b11 and disable writes 2'b00.
- R4: IDs 13 and 14 own bit (id-13) of control image B, and enable sets that bit. These devices cannot be disabled. A disable request for them leaves both images unchanged and raises `reject_o` for one cycle.
- R5: An accepted request changes no bit of either image outside the target field.
- R6: A request with an ID from 15 to 31 changes neither image and raises `bad_id_o` for one cycle.
- R7: Image updates and flags appear at the clock edge that samples `req_valid_i`. Both flags are low in any cycle that follows an edge with no request.
- R8: Query IDs 0 to 9 read `stat_a_i[3*id+2:3*id]`, and IDs 10 and 11 read `stat_b_i[3*(id-10)+2:3*(id-10)]`. A field value of 1 gives state 2'b01 (enabled), 0 gives 2'b00 (disabled), and any other value gives 2'b10 (other). The query output is combinational.
- R9: A query for an ID with no status field (12 to 31) returns 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe, one request per cycle |
| req_id_i | input | 5 | Target device ID |
| req_on_i | input | 1 | 1 = enable, 0 = disable |
| qry_id_i | input | 5 | Device ID for the status query |
| stat_a_i | input | 32 | First status word |
| stat_b_i | input | 32 | Second status word |
| ctl_a_o | output | 32 | Control image A |
| ctl_b_o | output | 32 | Control image B |
| bad_id_o | output | 1 | One-cycle pulse: request ID unmapped |
| reject_o | output | 1 | One-cycle pulse: disable refused |
| qry_state_o | output | 2 | Decoded state of the queried device |

## Verification
The bench targets the seams between ranges: ID 11 against ID 12, and ID 12 against ID 13. A lookup with an off-by-one bound would write the wrong register or miss a device there, and a wrong offset for ID 12 would land its 2'b11 code on bits 25:24 instead of 31:30. Every request is compared against a whole-register model. A mask that is too wide or too narrow would therefore show up as clobbered neighbour bits. Disable sweeps over IDs 13 and 14 catch a design that clears those bits, or that writes the all-ones off code into the image. Status sweeps over field values 0 to 7 and over IDs 9/10 and 11/12 catch a design that reports stray codes as enabled or reads the wrong status word.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  localparam int DW    = 32;
  localparam int LSB_W = 5;
  localparam int NB_W  = 6;

  localparam int N_CTL_RNG  = 3;
  localparam int N_STAT_RNG = 2;

  localparam logic [DW-1:0] NO_DISABLE = '1;

  typedef enum logic [1:0] {
    ST_DISABLED = 2'b00,
    ST_ENABLED  = 2'b01,
    ST_OTHER    = 2'b10,
    ST_UNMAPPED = 2'b11
  } dev_state_e;

  typedef struct packed {
    logic [31:0]   first_id;
    logic [31:0]   count;
    logic          bank;
    logic [DW-1:0] on_code;
    logic [DW-1:0] off_code;
    logic [31:0]   base_bit;
    logic [31:0]   width;
  } fld_rng_t;

  function automatic fld_rng_t mk_rng(input logic [31:0] f, input logic [31:0] c,
                                      input logic b, input logic [DW-1:0] on,
                                      input logic [DW-1:0] off, input logic [31:0] base,
                                      input logic [31:0] w);
    fld_rng_t r;
    r.first_id = f;
    r.count    = c;
    r.bank     = b;
    r.on_code  = on;
    r.off_code = off;
    r.base_bit = base;
    r.width    = w;
    return r;
  endfunction

  // Range tables: control (stat=0) and status (stat=1)
  function automatic fld_rng_t rng_at(input bit stat, input int idx);
    fld_rng_t r;
    r = '0;
    if (!stat) begin
      case (idx)
        0: r = mk_rng(32'd0,  32'd12, 1'b0, 32'd1, 32'd0,      32'd0,  32'd2);
        1: r = mk_rng(32'd12, 32'd1,  1'b0, 32'd3, 32'd0,      32'd30, 32'd2);
        2: r = mk_rng(32'd13, 32'd2,  1'b1, 32'd1, NO_DISABLE, 32'd0,  32'd1);
        default: r = '0;
      endcase
    end else begin
      case (idx)
        0: r = mk_rng(32'd0,  32'd10, 1'b0, 32'd1, 32'd0, 32'd0, 32'd3);
        1: r = mk_rng(32'd10, 32'd2,  1'b1, 32'd1, 32'd0, 32'd0, 32'd3);
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] fld_mask(input logic [LSB_W-1:0] lsb,
                                             input logic [NB_W-1:0] nb);
    logic [DW-1:0] m;
    if (int'(nb) >= DW) m = '1;
    else                m = (DW'(1) << nb) - DW'(1);
    return m << lsb;
  endfunction

  function automatic logic [DW-1:0] fld_insert(input logic [DW-1:0] word,
                                               input logic [DW-1:0] code,
                                               input logic [LSB_W-1:0] lsb,
                                               input logic [NB_W-1:0] nb);
    logic [DW-1:0] m;
    m = fld_mask(lsb, nb);
    return (word & ~m) | ((code << lsb) & m);
  endfunction

  function automatic logic [DW-1:0] fld_extract(input logic [DW-1:0] word,
                                                input logic [LSB_W-1:0] lsb,
                                                input logic [NB_W-1:0] nb);
    return (word >> lsb) & fld_mask('0, nb);
  endfunction

endpackage

// File: rtl/dsm_id_lookup.sv
module dsm_id_lookup
  import dsm_pkg::*;
#(
  parameter int ID_W     = 5,
  parameter bit STAT_MAP = 1'b0,
  parameter int N_RNG    = N_CTL_RNG
) (
  input  logic [ID_W-1:0]  id_i,
  output logic [N_RNG-1:0] hit_vec_o,
  output logic             bank_o,
  output logic [LSB_W-1:0] lsb_o,
  output logic [NB_W-1:0]  nbits_o,
  output logic [DW-1:0]    on_code_o,
  output logic [DW-1:0]    off_code_o
);

  logic [31:0] id32;
  assign id32 = 32'(id_i);

  logic             bank_v [N_RNG];
  logic [LSB_W-1:0] lsb_v  [N_RNG];
  logic [NB_W-1:0]  nb_v   [N_RNG];
  logic [DW-1:0]    on_v   [N_RNG];
  logic [DW-1:0]    off_v  [N_RNG];

  for (genvar g = 0; g < N_RNG; g++) begin : g_rng
    localparam fld_rng_t RNG = rng_at(STAT_MAP, g);
    logic [31:0] ofs;
    assign ofs            = id32 - RNG.first_id;
    assign hit_vec_o[g]   = (id32 >= RNG.first_id) && (id32 < RNG.first_id + RNG.count);
    assign lsb_v[g]       = LSB_W'(RNG.base_bit + ofs * RNG.width);
    assign nb_v[g]        = NB_W'(RNG.width);
    assign bank_v[g]      = RNG.bank;
    assign on_v[g]        = RNG.on_code;
    assign off_v[g]       = RNG.off_code;
  end

  // Lowest-numbered hit wins (ranges do not overlap)
  always_comb begin
    bank_o     = 1'b0;
    lsb_o      = '0;
    nbits_o    = '0;
    on_code_o  = '0;
    off_code_o = '0;
    for (int i = N_RNG - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) begin
        bank_o     = bank_v[i];
        lsb_o      = lsb_v[i];
        nbits_o    = nb_v[i];
        on_code_o  = on_v[i];
        off_code_o = off_v[i];
      end
    end
  end

endmodule

// File: rtl/dsm_ctl_bank.sv
module dsm_ctl_bank
  import dsm_pkg::*;
#(
  parameter logic [DW-1:0] RST_A = '0,
  parameter logic [DW-1:0] RST_B = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             bad_i,
  input  logic             rej_i,
  input  logic             bank_i,
  input  logic [LSB_W-1:0] lsb_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic [DW-1:0]    code_i,
  output logic [DW-1:0]    ctl_a_o,
  output logic [DW-1:0]    ctl_b_o,
  output logic             bad_o,
  output logic             rej_o
);

  logic [DW-1:0] cur, nxt;

  assign cur = bank_i ? ctl_b_o : ctl_a_o;
  assign nxt = fld_insert(cur, code_i, lsb_i, nbits_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a_o <= RST_A;
      ctl_b_o <= RST_B;
      bad_o   <= 1'b0;
      rej_o   <= 1'b0;
    end else begin
      bad_o <= bad_i;
      rej_o <= rej_i;
      if (fire_i && !bank_i) ctl_a_o <= nxt;
      if (fire_i &&  bank_i) ctl_b_o <= nxt;
    end
  end

endmodule

// File: rtl/dsm_stat_decode.sv
module dsm_stat_decode
  import dsm_pkg::*;
(
  input  logic             hit_i,
  input  logic [DW-1:0]    word_i,
  input  logic [LSB_W-1:0] lsb_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic [DW-1:0]    on_code_i,
  input  logic [DW-1:0]    off_code_i,
  output dev_state_e       state_o
);

  logic [DW-1:0] fld, wmask;

  assign fld   = fld_extract(word_i, lsb_i, nbits_i);
  assign wmask = fld_mask('0, nbits_i);

  always_comb begin
    if (!hit_i)                          state_o = ST_UNMAPPED;
    else if (fld == (on_code_i & wmask))  state_o = ST_ENABLED;
    else if (fld == (off_code_i & wmask)) state_o = ST_DISABLED;
    else                                 state_o = ST_OTHER;
  end

endmodule

// File: rtl/dsm_devstate_mapper.sv
module dsm_devstate_mapper
  import dsm_pkg::*;
#(
  parameter int              ID_W  = 5,
  parameter logic [DW-1:0]   RST_A = '0,
  parameter logic [DW-1:0]   RST_B = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic [ID_W-1:0] req_id_i,
  input  logic            req_on_i,
  input  logic [ID_W-1:0] qry_id_i,
  input  logic [DW-1:0]   stat_a_i,
  input  logic [DW-1:0]   stat_b_i,
  output logic [DW-1:0]   ctl_a_o,
  output logic [DW-1:0]   ctl_b_o,
  output logic            bad_id_o,
  output logic            reject_o,
  output logic [1:0]      qry_state_o
);

  // control side
  logic [N_CTL_RNG-1:0] ctl_hit_vec;
  logic                 ctl_hit;
  logic                 ctl_bank;
  logic [LSB_W-1:0]     ctl_lsb;
  logic [NB_W-1:0]      ctl_nb;
  logic [DW-1:0]        ctl_on, ctl_off, ctl_code;
  logic                 ctl_fire, ctl_bad, ctl_rej;

  dsm_id_lookup #(.ID_W(ID_W), .STAT_MAP(1'b0), .N_RNG(N_CTL_RNG)) u_ctl_lu (
    .id_i       (req_id_i),
    .hit_vec_o  (ctl_hit_vec),
    .bank_o     (ctl_bank),
    .lsb_o      (ctl_lsb),
    .nbits_o    (ctl_nb),
    .on_code_o  (ctl_on),
    .off_code_o (ctl_off)
  );

  assign ctl_hit  = |ctl_hit_vec;
  assign ctl_code = req_on_i ? ctl_on : ctl_off;
  assign ctl_rej  = req_valid_i && ctl_hit && !req_on_i && (ctl_off == NO_DISABLE);
  assign ctl_bad  = req_valid_i && !ctl_hit;
  assign ctl_fire = req_valid_i && ctl_hit && !ctl_rej;

  dsm_ctl_bank #(.RST_A(RST_A), .RST_B(RST_B)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (ctl_fire),
    .bad_i   (ctl_bad),
    .rej_i   (ctl_rej),
    .bank_i  (ctl_bank),
    .lsb_i   (ctl_lsb),
    .nbits_i (ctl_nb),
    .code_i  (ctl_code),
    .ctl_a_o (ctl_a_o),
    .ctl_b_o (ctl_b_o),
    .bad_o   (bad_id_o),
    .rej_o   (reject_o)
  );

  // status side
  logic [N_STAT_RNG-1:0] stat_hit_vec;
  logic                  stat_hit;
  logic                  stat_bank;
  logic [LSB_W-1:0]      stat_lsb;
  logic [NB_W-1:0]       stat_nb;
  logic [DW-1:0]         stat_on, stat_off, stat_word;
  dev_state_e            stat_state;

  dsm_id_lookup #(.ID_W(ID_W), .STAT_MAP(1'b1), .N_RNG(N_STAT_RNG)) u_stat_lu (
    .id_i       (qry_id_i),
    .hit_vec_o  (stat_hit_vec),
    .bank_o     (stat_bank),
    .lsb_o      (stat_lsb),
    .nbits_o    (stat_nb),
    .on_code_o  (stat_on),
    .off_code_o (stat_off)
  );

  assign stat_hit  = |stat_hit_vec;
  assign stat_word = stat_bank ? stat_b_i : stat_a_i;

  dsm_stat_decode u_dec (
    .hit_i      (stat_hit),
    .word_i     (stat_word),
    .lsb_i      (stat_lsb),
    .nbits_i    (stat_nb),
    .on_code_i  (stat_on),
    .off_code_i (stat_off),
    .state_o    (stat_state)
  );

  assign qry_state_o = stat_state;

endmodule

// File: rtl/dsm_devstate_chk.sv
module dsm_devstate_chk
  import dsm_pkg::*;
#(
  parameter int ID_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [ID_W-1:0]       req_id,
  input logic                  req_on,
  input logic [DW-1:0]         ctl_a,
  input logic [DW-1:0]         ctl_b,
  input logic                  bad_id,
  input logic                  reject,
  input logic [N_CTL_RNG-1:0]  ctl_hit_vec,
  input logic                  ctl_hit,
  input logic [DW-1:0]         ctl_off,
  input logic                  stat_hit,
  input logic [1:0]            qry_state
);

  // R5
  ctl_range_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_hit_vec));

  // R6
  bad_id_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ctl_hit) |=> (bad_id && !reject && $stable(ctl_a) && $stable(ctl_b)));

  // R4
  no_disable_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ctl_hit && !req_on && ctl_off == NO_DISABLE)
      |=> (reject && !bad_id && $stable(ctl_a) && $stable(ctl_b)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!bad_id && !reject && $stable(ctl_a) && $stable(ctl_b)));

  // R3
  top_field_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id == ID_W'(12) && req_on) |=> (ctl_a[31:30] == 2'b11));

  // R4
  fixed_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id == ID_W'(13) && req_on) |=> ctl_b[0]);

  // R9
  unmapped_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_hit |-> (qry_state == 2'b11));

endmodule

bind dsm_devstate_mapper dsm_devstate_chk #(.ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid_i),
  .req_id      (req_id_i),
  .req_on      (req_on_i),
  .ctl_a       (ctl_a_o),
  .ctl_b       (ctl_b_o),
  .bad_id      (bad_id_o),
  .reject      (reject_o),
  .ctl_hit_vec (ctl_hit_vec),
  .ctl_hit     (ctl_hit),
  .ctl_off     (ctl_off),
  .stat_hit    (stat_hit),
  .qry_state   (qry_state_o)
);

// File: tb/sim_dsm_devstate_mapper.sv
`timescale 1ns/1ps
module sim_dsm_devstate_mapper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [4:0]  req_id_i;
  logic        req_on_i;
  logic [4:0]  qry_id_i;
  logic [31:0] stat_a_i, stat_b_i;
  logic [31:0] ctl_a_o, ctl_b_o;
  logic        bad_id_o, reject_o;
  logic [1:0]  qry_state_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] ma, mb;

  always #2.5 clk = ~clk;

  dsm_devstate_mapper u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_id_i(req_id_i),
    .req_on_i(req_on_i), .qry_id_i(qry_id_i), .stat_a_i(stat_a_i), .stat_b_i(stat_b_i),
    .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o), .bad_id_o(bad_id_o), .reject_o(reject_o),
    .qry_state_o(qry_state_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int id);
    if (id < 12)      return "R2 R5";
    else if (id == 12) return "R3 R5";
    else if (id < 15) return "R4 R5";
    else              return "R6";
  endfunction

  // Issue one request, update the model, compare after the capturing edge
  task automatic do_req(input int id, input bit on);
    bit exp_bad, exp_rej;
    exp_bad = 1'b0;
    exp_rej = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_id_i    = 5'(id);
    req_on_i    = on;
    if (id < 12)       ma[2*id +: 2] = on ? 2'd1 : 2'd0;
    else if (id == 12) ma[31:30]     = on ? 2'd3 : 2'd0;
    else if (id < 15) begin
      if (on) mb[id-13] = 1'b1;
      else    exp_rej   = 1'b1;
    end else exp_bad = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(ctl_a_o == ma, tag_of(id), 64'(ctl_a_o), 64'(ma));
    check(ctl_b_o == mb, tag_of(id), 64'(ctl_b_o), 64'(mb));
    check(bad_id_o == exp_bad, "R6 R7", 64'(bad_id_o), 64'(exp_bad));
    check(reject_o == exp_rej, "R4 R7", 64'(reject_o), 64'(exp_rej));
  endtask

  task automatic idle_chk;
    @(negedge clk);
    check(!bad_id_o && !reject_o, "R7 flags clear", {bad_id_o, reject_o}, 0);
    check(ctl_a_o == ma && ctl_b_o == mb, "R7 idle hold", 64'(ctl_a_o), 64'(ma));
  endtask

  function automatic logic [1:0] exp_state(input int id, input logic [31:0] sa,
                                           input logic [31:0] sb);
    logic [2:0] f;
    if (id < 10)      f = sa[3*id +: 3];
    else if (id < 12) f = sb[3*(id-10) +: 3];
    else              return 2'b11;
    if (f == 3'd1)      return 2'b01;
    else if (f == 3'd0) return 2'b00;
    else                return 2'b10;
  endfunction

  task automatic stat_sweep(input logic [31:0] sa, input logic [31:0] sb);
    for (int q = 0; q < 32; q++) begin
      @(negedge clk);
      stat_a_i = sa;
      stat_b_i = sb;
      qry_id_i = 5'(q);
      #1;
      check(qry_state_o == exp_state(q, sa, sb), (q < 12) ? "R8" : "R9",
            64'(qry_state_o), 64'(exp_state(q, sa, sb)));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid_i = 1'b0; req_id_i = '0; req_on_i = 1'b0;
    qry_id_i = '0; stat_a_i = '0; stat_b_i = '0;
    ma = '0; mb = '0;
    repeat (3) @(negedge clk);
    // R1
    check(ctl_a_o == 0 && ctl_b_o == 0, "R1 images in reset", 64'(ctl_a_o), 0);
    check(!bad_id_o && !reject_o, "R1 flags in reset", {bad_id_o, reject_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctl_a_o == 0 && ctl_b_o == 0, "R1 images after reset", 64'(ctl_b_o), 0);

    // enable sweep ascending, then disable sweep ascending
    for (int id = 0; id < 32; id++) do_req(id, 1'b1);
    idle_chk();
    for (int id = 0; id < 32; id++) do_req(id, 1'b0);
    idle_chk();
    // alternating pattern, descending order, back-to-back requests
    for (int id = 31; id >= 0; id--) do_req(id, id[0]);
    for (int id = 0; id < 32; id += 3) do_req(id, 1'b1);
    idle_chk();
    // seam IDs, repeated to confirm idempotence and neighbour preservation
    do_req(11, 1'b1); do_req(12, 1'b0); do_req(12, 1'b1); do_req(11, 1'b0);
    do_req(13, 1'b0); do_req(14, 1'b0); do_req(15, 1'b1); do_req(0, 1'b0);
    idle_chk();

    // status sweeps
    stat_sweep(32'h0000_0000, 32'h0000_0000);
    stat_sweep(32'h0924_9249, 32'h0000_0009);
    stat_sweep(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int p = 0; p < 8; p++) begin
      logic [31:0] sa, sb;
      sa = '0;
      sb = '0;
      for (int k = 0; k < 10; k++) sa[3*k +: 3] = 3'((p + k) % 8);
      sb[2:0] = 3'(p);
      sb[5:3] = 3'(7 - p);
      sb[31:6] = 26'h2AA_AAAA;
      stat_sweep(sa, sb);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule